// File: doc/BRIEF.md
# Frame-Synchronized Serial Word Receiver

This block is the receive half of a synchronous serial port that faces a 16-bit audio converter. The converter supplies the shift clock and a frame-sync pulse, so both arrive as plain inputs. Each of them passes through a chain of synchronizer flops into the system clock domain, and edges of the shift clock are detected there. A frame-sync pulse marks the first bit of a word with no bit delay. Each frame carries one word, most significant bit first, and the block samples data on the falling edge of the shift clock.

The word is assembled in a shift register. This register is separate from the data register that the rest of the chip reads, so assembly of the next word can go on while the previous one waits. When a word completes it moves into the data register and raises a ready flag. A DMA channel or a processor can use that flag as its trigger, reading the same register address every time. A read clears the flag. A word that completes while the register still holds an unread word overwrites it and sets a sticky overrun flag. A frame-sync pulse in the middle of a word discards the partial word, starts a new one and sets a sticky frame-error flag.

Top module: `fsrx_top`

## Requirements
- R1: While reset is asserted, and until the first completed word, the data output is zero and the ready, overrun and frame-error outputs are low.
- R2: Serial data is taken on the falling edge of the shift clock, as seen after the synchronizer chain. A data bit that changes on the rising edge and holds through the falling edge is the bit received.
- R3: With zero bit delay, the bit sampled on the same falling edge at which frame sync is high is the first bit of the word.
- R4: The first bit of a word lands in bit 15 of the data output and the last in bit 0, so the order is most significant bit first.
- R5: A frame holds exactly 16 bits. Bits that follow the sixteenth without a new frame sync are ignored: no word completes and the data register keeps its value.
- R6: Ready rises, and the data output shows the completed word, at most SYNC_STAGES+2 system clocks after the falling shift-clock edge of the sixteenth bit reaches the pin.
- R7: Ready stays high until a read strobe arrives while it is high, and it is low on the next cycle. A read strobe while ready is low has no effect on any output.
- R8: If a word completes while ready is high and no read strobe is present in that cycle, the new word replaces the old one, ready stays high and overrun is set.
- R9: If a word completes in the same cycle as a read strobe, the new word is loaded, ready stays high and overrun is not set.
- R10: A frame sync sampled after 1 to 15 bits of a word discards those bits, takes the current bit as the new first bit and sets frame-error.
- R11: Overrun and frame-error, once set, stay set until reset.
- R12: Falling shift-clock edges with frame sync low and no word in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | External shift clock, asynchronous to clk |
| fsync_i | input | 1 | External frame-sync pulse, active high |
| sdat_i | input | 1 | Serial data in |
| rd_i | input | 1 | Read strobe for the data register, one clk cycle |
| rdata_o | output | WORD_W | Receive data register |
| rready_o | output | 1 | Receive-ready event, high while the register holds an unread word |
| overrun_o | output | 1 | Sticky overrun flag |
| frame_err_o | output | 1 | Sticky early-frame-sync flag |

## Verification
The bench builds the block with its defaults: 16-bit words, two synchronizer stages, falling-edge sampling and most-significant-first order. These are the converter's settings, so every corner in the list above can be reached. The shift clock runs at eight system clocks per bit, which leaves room for the full synchronizer latency between edges. The bench times one read strobe from its own model so that it lands in the exact cycle a word completes, which exercises the read-versus-completion race. It also sends early frame syncs, bits after a complete frame, and edges with no frame at all.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;

   typedef enum logic {
      ORDER_MSB = 1'b0,
      ORDER_LSB = 1'b1
   } bit_order_e;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } smp_edge_e;

   // width needed to count 0..n inclusive
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/fsrx_sync.sv
module fsrx_sync
   import fsrx_pkg::*;
#(
   parameter int unsigned STAGES = 2,
   parameter smp_edge_e   EDGE   = EDGE_FALL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic fsync_i,
   input  logic sdat_i,
   output logic smp_o,
   output logic fs_o,
   output logic dat_o
);

   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] clk_pipe;
   logic [STAGES-1:0] fs_pipe;
   logic [STAGES-1:0] dat_pipe;
   logic              clk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_pipe <= '0;
         fs_pipe  <= '0;
         dat_pipe <= '0;
         clk_prev <= 1'b0;
      end else begin
         clk_pipe <= {clk_pipe[STAGES-2:0], sclk_i};
         fs_pipe  <= {fs_pipe[STAGES-2:0], fsync_i};
         dat_pipe <= {dat_pipe[STAGES-2:0], sdat_i};
         clk_prev <= clk_pipe[LAST];
      end
   end

   generate
      if (EDGE == EDGE_FALL) begin : g_fall
         assign smp_o = clk_prev & ~clk_pipe[LAST];
      end else begin : g_rise
         assign smp_o = ~clk_prev & clk_pipe[LAST];
      end
   endgenerate

   assign fs_o  = fs_pipe[LAST];
   assign dat_o = dat_pipe[LAST];

   // R2: a detected edge cannot repeat on the next cycle
   a_r2_edge_isolated : assert property (@(posedge clk) disable iff (!rst_n)
      smp_o |=> !smp_o);

endmodule

// File: rtl/fsrx_shift.sv
module fsrx_shift
   import fsrx_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter bit_order_e  ORDER  = ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_i,
   input  logic              fs_i,
   input  logic              dat_i,
   output logic              done_o,
   output logic [WORD_W-1:0] word_o,
   output logic              ferr_o
);

   localparam int unsigned CW = cnt_width(WORD_W);
   localparam logic [CW-1:0] FULL = CW'(WORD_W);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0]     cnt_q;
   logic [CW-1:0]     cnt_nx;
   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] base;
   logic [WORD_W-1:0] shifted;
   logic              active;
   logic              start;
   logic              cont;
   logic              take;
   logic              ferr_q;

   always_comb begin
      active = (cnt_q != '0);
      start  = smp_i & fs_i;
      cont   = smp_i & ~fs_i & active;
      take   = start | cont;
      base   = start ? '0 : sh_q;
      cnt_nx = start ? ONE : cnt_q + ONE;
   end

   generate
      if (ORDER == ORDER_MSB) begin : g_msb
         assign shifted = {base[WORD_W-2:0], dat_i};
      end else begin : g_lsb
         assign shifted = {dat_i, base[WORD_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sh_q   <= '0;
         ferr_q <= 1'b0;
      end else begin
         if (take) begin
            sh_q  <= shifted;
            cnt_q <= (cnt_nx == FULL) ? '0 : cnt_nx;
         end
         if (start && active) begin
            ferr_q <= 1'b1;
         end
      end
   end

   assign done_o = take & (cnt_nx == FULL);
   assign word_o = shifted;
   assign ferr_o = ferr_q;

   // R11: frame error is sticky
   a_r11_ferr_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      ferr_o |=> ferr_o);

   // R10: an early frame sync restarts at bit one and flags the error
   a_r10_restart : assert property (@(posedge clk) disable iff (!rst_n)
      (smp_i && fs_i && cnt_q != '0) |=> (cnt_q == ONE && ferr_o));

   // R5: after a completed word no bit is pending
   a_r5_idle_after_word : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (cnt_q == '0));

   // R12: no edge, no progress
   a_r12_hold_without_edge : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_i |=> $stable(cnt_q));

endmodule

// File: rtl/fsrx_hold.sv
module fsrx_hold #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              rd_i,
   output logic [WORD_W-1:0] data_o,
   output logic              ready_o,
   output logic              ovr_o
);

   logic [WORD_W-1:0] data_q;
   logic              ready_q;
   logic              ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q  <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (done_i) begin
         data_q  <= word_i;
         ready_q <= 1'b1;
         if (ready_q && !rd_i) begin
            ovr_q <= 1'b1;
         end
      end else if (rd_i) begin
         ready_q <= 1'b0;
      end
   end

   assign data_o  = data_q;
   assign ready_o = ready_q;
   assign ovr_o   = ovr_q;

   // R7: ready holds until read
   a_r7_ready_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && !rd_i && !done_i) |=> ready_o);

   // R7: a read of a full register empties it
   a_r7_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && rd_i && !done_i) |=> !ready_o);

   // R8: completion on a full, unread register flags overrun
   a_r8_overrun_set : assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && ready_o && !rd_i) |=> (ovr_o && ready_o));

   // R9: completion with a simultaneous read leaves overrun alone
   a_r9_read_race : assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && rd_i && !ovr_o) |=> (!ovr_o && ready_o));

   // R11: overrun is sticky
   a_r11_ovr_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      ovr_o |=> ovr_o);

endmodule

// File: rtl/fsrx_top.sv
module fsrx_top
   import fsrx_pkg::*;
#(
   parameter int unsigned WORD_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter smp_edge_e   SAMPLE_EDGE = EDGE_FALL,
   parameter bit_order_e  BIT_ORDER   = ORDER_MSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              fsync_i,
   input  logic              sdat_i,
   input  logic              rd_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic              rready_o,
   output logic              overrun_o,
   output logic              frame_err_o
);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("fsrx_top: WORD_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("fsrx_top: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              smp;
   logic              fs_s;
   logic              dat_s;
   logic              done;
   logic [WORD_W-1:0] word;

   fsrx_sync #(
      .STAGES (SYNC_STAGES),
      .EDGE   (SAMPLE_EDGE)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_i  (sclk_i),
      .fsync_i (fsync_i),
      .sdat_i  (sdat_i),
      .smp_o   (smp),
      .fs_o    (fs_s),
      .dat_o   (dat_s)
   );

   fsrx_shift #(
      .WORD_W (WORD_W),
      .ORDER  (BIT_ORDER)
   ) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (smp),
      .fs_i   (fs_s),
      .dat_i  (dat_s),
      .done_o (done),
      .word_o (word),
      .ferr_o (frame_err_o)
   );

   fsrx_hold #(
      .WORD_W (WORD_W)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_i  (done),
      .word_i  (word),
      .rd_i    (rd_i),
      .data_o  (rdata_o),
      .ready_o (rready_o),
      .ovr_o   (overrun_o)
   );

   // R6: ready only rises with a completed word
   a_r6_ready_from_word : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rready_o) |-> $past(done));

endmodule

// File: tb/tb_fsrx_top.sv
module tb_fsrx_top;

   localparam int W  = 16;
   localparam int S  = 2;
   localparam int HP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic fsync = 1'b0;
   logic sdat = 1'b0;
   logic rd_task = 1'b0;
   logic rd_auto = 1'b0;
   logic rd;
   logic arm = 1'b0;
   logic [W-1:0] rdata;
   logic rready, ovr, ferr;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done_flag = 0;

   assign rd = rd_task | rd_auto;

   always #10 clk = ~clk;

   fsrx_top #(.WORD_W(W), .SYNC_STAGES(S)) dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .fsync_i(fsync), .sdat_i(sdat),
      .rd_i(rd), .rdata_o(rdata), .rready_o(rready), .overrun_o(ovr),
      .frame_err_o(ferr)
   );

   // behavioural reference model
   logic qc[$];
   logic qf[$];
   logic qd[$];
   logic m_prev;
   int   m_cnt;
   logic [W-1:0] m_sh, m_word;
   logic m_ready, m_ovr, m_ferr;

   task automatic model_reset();
      qc = {}; qf = {}; qd = {};
      for (int i = 0; i < S; i++) begin
         qc.push_back(1'b0); qf.push_back(1'b0); qd.push_back(1'b0);
      end
      m_prev = 0; m_cnt = 0; m_sh = '0; m_word = '0;
      m_ready = 0; m_ovr = 0; m_ferr = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         logic ev, f, d, fin;
         logic [W-1:0] nw;
         ev = m_prev && !qc[0];
         f = qf[0];
         d = qd[0];
         fin = 0;
         nw = '0;
         if (ev && f) begin
            if (m_cnt != 0) m_ferr = 1;
            m_sh = {{(W-1){1'b0}}, d};
            m_cnt = 1;
         end else if (ev && m_cnt != 0) begin
            m_sh = {m_sh[W-2:0], d};
            m_cnt++;
         end
         if (m_cnt == W) begin
            fin = 1; nw = m_sh; m_cnt = 0;
         end
         if (fin) begin
            if (m_ready && !rd) m_ovr = 1;
            m_word = nw;
            m_ready = 1;
         end else if (rd) begin
            m_ready = 0;
         end
         m_prev = qc[0];
         void'(qc.pop_front()); qc.push_back(sclk);
         void'(qf.pop_front()); qf.push_back(fsync);
         void'(qd.pop_front()); qd.push_back(sdat);
      end
   end

   // read strobe timed from the model onto a completion cycle (R9)
   always @(negedge clk) begin
      if (arm && rst_n && m_prev && !qc[0] && !qf[0] && m_cnt == W-1)
         rd_auto = 1'b1;
      else
         rd_auto = 1'b0;
   end

   // cycle-by-cycle comparison against the model (R2, R6)
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         checks++;
         if (rdata !== m_word || rready !== m_ready || ovr !== m_ovr || ferr !== m_ferr) begin
            errors++;
            $display("FAIL R6 model cycle %0d: act word=%h rdy=%b ovr=%b ferr=%b exp word=%h rdy=%b ovr=%b ferr=%b",
                     cycles, rdata, rready, ovr, ferr, m_word, m_ready, m_ovr, m_ferr);
         end
      end
   end

   task automatic finish_run();
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog: act cycles=%0d exp below 150000", cycles);
         finish_run();
      end
   end

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic shift_bit(input logic b, input logic f);
      @(negedge clk);
      sclk = 1'b1; sdat = b; fsync = f;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
      repeat (HP - 1) @(negedge clk);
   endtask

   task automatic send_bits(input logic [W-1:0] w, input int n, input bit with_fs);
      for (int i = 0; i < n; i++) shift_bit(w[W-1-i], with_fs && i == 0);
      @(negedge clk);
      sclk = 1'b1; fsync = 1'b0;
      repeat (S + 4) @(negedge clk);
   endtask

   task automatic do_read();
      @(negedge clk); rd_task = 1'b1;
      @(negedge clk); rd_task = 1'b0;
      @(negedge clk);
   endtask

   task automatic apply_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 word", rdata, '0);
      check("R1 ready", W'(rready), '0);
      check("R1 overrun", W'(ovr), '0);
      check("R1 frame_err", W'(ferr), '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      apply_reset();

      // R12: edges with no frame
      send_bits(16'hFFFF, 5, 0);
      check("R12 ready", W'(rready), '0);
      check("R12 word", rdata, '0);

      // R3 R4 R2: first bit with frame sync lands in bit 15
      send_bits(16'hA5C3, W, 1);
      check("R4 word msb first", rdata, 16'hA5C3);
      check("R3 ready after frame", W'(rready), 1);
      do_read();
      check("R7 read clears", W'(rready), '0);
      do_read();
      check("R7 idle read ready", W'(rready), '0);
      check("R7 idle read word", rdata, 16'hA5C3);
      check("R7 idle read ovr", W'(ovr), '0);

      // R5: bits beyond the frame are ignored
      send_bits(16'h1234, W, 1);
      send_bits(16'hFFFF, W, 0);
      check("R5 word kept", rdata, 16'h1234);
      check("R5 no overrun", W'(ovr), '0);
      do_read();

      // R8: overrun
      send_bits(16'h0F0F, W, 1);
      send_bits(16'hBEEF, W, 1);
      check("R8 word replaced", rdata, 16'hBEEF);
      check("R8 overrun", W'(ovr), 1);
      check("R8 ready", W'(rready), 1);
      do_read();
      check("R11 overrun sticky", W'(ovr), 1);

      // R10: early frame sync
      send_bits(16'hFFFF, 5, 1);
      check("R10 no early flag", W'(ferr), '0);
      send_bits(16'h8001, W, 1);
      check("R10 frame_err", W'(ferr), 1);
      check("R10 word restarted", rdata, 16'h8001);
      do_read();
      check("R11 frame_err sticky", W'(ferr), 1);

      apply_reset();

      // R9: read in the completion cycle
      send_bits(16'h1111, W, 1);
      check("R9 first pending", W'(rready), 1);
      arm = 1'b1;
      send_bits(16'h2222, W, 1);
      arm = 1'b0;
      check("R9 new word", rdata, 16'h2222);
      check("R9 ready", W'(rready), 1);
      check("R9 no overrun", W'(ovr), '0);

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule